// File: doc/BRIEF.md
# Charge Counter with Window Count

This block integrates current over time for modules that sense current only. A measurement front end closes a fixed 200 ms window (1/18000 hour) and presents that window's RMS current in milliamps together with a one-cycle done strobe. Each strobe adds the current to a running total that is kept as an exact quotient and remainder of division by 1800. The quotient is the charge in units of 0.1 mA·h. A second counter records how many windows have been integrated, so that the host can work out the average current.

Both results are 32 bits wide by default and are laid out little-endian for byte access: bits [7:0] form the least significant byte and bits [31:24] the most significant. A one-cycle clear strobe, raised when the host issues its charge-reset command, returns the charge, the window count and the hidden remainder to zero. Both values are volatile and live only in flops.

Top module: `coulomb_acc`

## Requirements
- R1: After reset, `charge_o` and `count_o` are both zero.
- R2: On a window strobe without clear, the charge rises by floor((rem + cur_ma_i) / 1800), and the remainder becomes (rem + cur_ma_i) mod 1800. The result is visible in the cycle after the strobe, so while unsaturated the charge always equals floor(sum of all mA since clear / 1800).
- R3: On a window strobe without clear, `count_o` rises by exactly one in the cycle after the strobe.
- R4: Without a window strobe or clear, `charge_o` and `count_o` hold, whatever value `cur_ma_i` has.
- R5: A clear strobe zeroes the charge, the count and the remainder in the following cycle. A window of 1799 mA, then a clear, then a window of 1 mA leaves the charge at 0.
- R6: When clear and window strobes arrive in the same cycle, the clear wins and that window's current and count are discarded.
- R7: The charge saturates at its all-ones maximum instead of wrapping.
- R8: The window count saturates at its all-ones maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_i | input | 1 | Window-done strobe, one cycle |
| cur_ma_i | input | CUR_W (16) | RMS current of the finished window, mA |
| clr_i | input | 1 | Clear strobe from the charge-reset command |
| charge_o | output | ACC_W (32) | Accumulated charge, 0.1 mA·h, little-endian byte order |
| count_o | output | ACC_W (32) | Number of windows integrated, little-endian byte order |

## Verification
The bench builds two copies side by side and drives both with identical stimulus. One copy uses the default 32-bit accumulators. The other uses 8-bit accumulators, so that charge saturation is reached within a few full-scale windows and count saturation after 255 windows. Both are compared on every clock against a behavioural model that tracks the remainder carry. This lets the exactness of the carry, the clear-over-window priority and both saturation limits be checked in a short run.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;
  localparam int DEF_DIV   = 1800;
  localparam int DEF_CUR_W = 16;
  localparam int DEF_ACC_W = 32;

  // width holding remainder (< div) plus one full-scale current sample
  function automatic int sum_bits(input int cur_w, input int div);
    return $clog2(div + (1 << cur_w));
  endfunction
endpackage

// File: rtl/charge_divider.sv
module charge_divider
  import coulomb_pkg::*;
#(
  parameter int CUR_W = DEF_CUR_W,
  parameter int DIV   = DEF_DIV,
  localparam int SUM_W = sum_bits(CUR_W, DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CUR_W-1:0] cur_i,
  output logic [SUM_W-1:0] quot_o
);
  localparam int REM_W = $clog2(DIV);
  localparam logic [SUM_W-1:0] DIV_L = SUM_W'(DIV);

  logic [REM_W-1:0] rem_q;
  logic [SUM_W-1:0] sum;

  assign sum    = SUM_W'(rem_q) + SUM_W'(cur_i);
  assign quot_o = sum / DIV_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (clr_i)  rem_q <= '0;
    else if (en_i)   rem_q <= REM_W'(sum % DIV_L);
  end

  // R5
  rem_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rem_q == '0);
  // R2
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |=> rem_q < REM_W'(DIV));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     val_o
);
  localparam int SW = ((W > INC_W) ? W : INC_W) + 1;
  localparam logic [SW-1:0] MAX_S = SW'({W{1'b1}});

  logic [W-1:0]  val_q;
  logic [SW-1:0] sum;

  assign sum   = SW'(val_q) + SW'(inc_i);
  assign val_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (en_i)   val_q <= (sum > MAX_S) ? '1 : W'(sum);
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> val_o == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !en_i |=> $stable(val_o));
  // R7
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && (&val_o) |=> &val_o);
  // R2
  grow_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> val_o >= $past(val_o));
endmodule

// File: rtl/coulomb_acc.sv
module coulomb_acc
  import coulomb_pkg::*;
#(
  parameter int CUR_W = DEF_CUR_W,
  parameter int ACC_W = DEF_ACC_W,
  parameter int DIV   = DEF_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_i,
  input  logic [CUR_W-1:0] cur_ma_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] charge_o,
  output logic [ACC_W-1:0] count_o
);
  localparam int SUM_W = sum_bits(CUR_W, DIV);

  logic             step;
  logic [SUM_W-1:0] quot;

  assign step = win_i & ~clr_i;

  charge_divider #(.CUR_W(CUR_W), .DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (step),
    .cur_i  (cur_ma_i),
    .quot_o (quot)
  );

  sat_counter #(.W(ACC_W), .INC_W(SUM_W)) u_charge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (step),
    .inc_i  (quot),
    .val_o  (charge_o)
  );

  sat_counter #(.W(ACC_W), .INC_W(1)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (step),
    .inc_i  (1'b1),
    .val_o  (count_o)
  );

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i && !clr_i && !(&count_o) |=> count_o == $past(count_o) + 1'b1);
  // R6
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i && clr_i |=> count_o == '0 && charge_o == '0);
  // R8
  count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i && !clr_i && (&count_o) |=> &count_o);
endmodule

// File: tb/coulomb_acc_bench.sv
module coulomb_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] cur = '0;
  logic [31:0] chg_a, cnt_a;
  logic [7:0]  chg_b, cnt_b;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 0;

  longint m_rem, m_qa, m_na, m_qb, m_nb;
  localparam longint MAX_A = 64'hFFFF_FFFF;
  localparam longint MAX_B = 255;

  always #(CLK_PERIOD/2) clk = ~clk;

  coulomb_acc u_coulomb_acc (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .cur_ma_i(cur), .clr_i(clr),
    .charge_o(chg_a), .count_o(cnt_a));

  coulomb_acc #(.ACC_W(SMALL_W)) u_coulomb_acc_small (
    .clk_i(clk), .rst_ni(rst_n), .win_i(win), .cur_ma_i(cur), .clr_i(clr),
    .charge_o(chg_b), .count_o(cnt_b));

  function automatic longint sat(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_qa = 0; m_na = 0; m_qb = 0; m_nb = 0;
    end else if (clr) begin
      m_rem = 0; m_qa = 0; m_na = 0; m_qb = 0; m_nb = 0;
    end else if (win) begin
      longint s;
      s     = m_rem + longint'(cur);
      m_qa  = sat(m_qa + s / 1800, MAX_A);
      m_qb  = sat(m_qb + s / 1800, MAX_B);
      m_rem = s % 1800;
      m_na  = sat(m_na + 1, MAX_A);
      m_nb  = sat(m_nb + 1, MAX_B);
    end
  end

  task automatic check(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("charge32", longint'(chg_a), m_qa);
    check("count32",  longint'(cnt_a), m_na);
    check("charge8",  longint'(chg_b), m_qb);
    check("count8",   longint'(cnt_b), m_nb);
  endtask

  // sample previous edge's result, then drive the next cycle's inputs
  task automatic step(input bit w, input int ma, input bit c);
    @(negedge clk);
    compare_all();
    win = w; cur = 16'(ma); clr = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    tag = "R1";
    step(0, 0, 0);
    check("reset charge", longint'(chg_a), 0);
    check("reset count",  longint'(cnt_a), 0);

    // R2 R3: varied currents, remainder carry
    tag = "R2";
    for (int i = 0; i < 5; i++) step(1, 1000, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("5x1000 charge", longint'(chg_a), 2);
    tag = "R3";
    check("5x1000 count", longint'(cnt_a), 5);
    tag = "R2";
    for (int i = 0; i < 4; i++) step(1, 65535, 0);
    for (int i = 0; i < 7; i++) step(1, 333 * i + 17, 0);
    step(1, 10000, 0); step(1, 0, 0);

    // R4: current toggles while no strobe
    tag = "R4";
    for (int i = 0; i < 6; i++) step(0, 12345 + i, 0);
    step(0, 0, 0);

    // R5: remainder lost on clear
    tag = "R5";
    step(1, 1799, 0);
    step(1, 0, 1);
    step(1, 1, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("clear drops remainder", longint'(chg_a), 0);
    check("clear count", longint'(cnt_a), 1);

    // R2: exact carry, 1800 windows of 1 mA give one unit
    tag = "R2";
    step(0, 0, 1);
    for (int i = 0; i < 1800; i++) step(1, 1, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("1800x1mA charge", longint'(chg_a), 1);

    // R6: window in clear cycle discarded
    tag = "R6";
    step(0, 0, 1);
    step(1, 1, 0);
    step(1, 1799, 1);
    step(1, 1799, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("clear beats window charge", longint'(chg_a), 0);
    check("clear beats window count",  longint'(cnt_a), 1);

    // R7: small charge saturates
    tag = "R7";
    for (int i = 0; i < 10; i++) step(1, 65535, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("charge8 saturated", longint'(chg_b), 255);

    // R8: small count saturates
    tag = "R8";
    step(0, 0, 1);
    for (int i = 0; i < 260; i++) step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 0);
    check("count8 saturated", longint'(cnt_b), 255);
    check("count32 not saturated", longint'(cnt_a), 260);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule